// File: doc/BRIEF.md
# Trigger-to-Clock Delay Timer

This block measures the time, in cycles of a fast counting clock, between a start event and the next rising edge of the conversion clock. In equivalent-time sampling the resulting count tells software where, inside one conversion-clock period, a trigger fell. Software uses that position to place the samples of each sweep. The start event is taken from one of two trigger gates. In calibration mode it is taken from the conversion clock itself.

Calibration gives software the two ends of the range the count can take. In maximum mode the block starts on one conversion-clock rise and stops on the following rise, which yields one full period. In minimum mode it starts and stops on the same rise, which yields the zero-interval count. Both are measured through the same synchronizer path that normal measurements use.

The processor must arm the timer before every measurement. Arming clears the count. The block then waits for the selected start edge, counts, and latches the result with a one-cycle completion pulse. The latched result holds until the next arm. The gates and the conversion clock are asynchronous. Each one passes through an identical two-stage synchronizer and an edge detector, so the fixed latency cancels out of the count.

Top module: `trig_delay_timer`

## Requirements
- R1: After reset, `count_o` is 0 and `done_o` is low.
- R2: When `cal_en`=0 and `src_sel`=0, a rising edge of `gate_a` starts the measurement. The latched count equals the number of clock cycles from that edge to the next rising edge of `conv_clk`, where both edges are taken as the clock cycle in which each input is first sampled high.
- R3: When `cal_en`=0 and `src_sel`=1, `gate_b` is the start source instead, and edges on `gate_a` have no effect on the result.
- R4: When a start edge and a `conv_clk` rise are sampled in the same cycle in gate mode, the count is 0.
- R5: When `cal_en`=1 and `cal_max`=1, a `conv_clk` rise starts the measurement and the following rise stops it, so the count equals the `conv_clk` period in cycles. Gate edges are ignored in this mode.
- R6: When `cal_en`=1 and `cal_max`=0, a `conv_clk` rise both starts and stops the measurement, so the count is 0.
- R7: The count saturates at 2^CNT_W-1 when the interval is longer than that.
- R8: `done_o` is high for exactly one cycle per measurement. The latched count stays unchanged after that pulse.
- R9: Raising `arm` for one cycle clears `count_o` to 0 in the following cycle. Start and stop edges that arrive while the timer is not armed produce no pulse and do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle pulse that arms the timer and clears the count |
| src_sel | input | 1 | Start source: 0 selects gate A, 1 selects gate B |
| cal_en | input | 1 | Calibration mode: the conversion clock is the start source |
| cal_max | input | 1 | In calibration: 1 selects the full-period measurement, 0 selects the zero measurement |
| gate_a | input | 1 | Asynchronous trigger gate A |
| gate_b | input | 1 | Asynchronous trigger gate B |
| conv_clk | input | 1 | Asynchronous conversion clock; its rising edge stops the count |
| count_o | output | CNT_W | Latched interval count |
| done_o | output | 1 | One-cycle pulse when the count latches |

## Verification
A wrong sequencer state shows up at the ports within a few cycles of the next edge. A timer that has dropped back to idle gives no completion pulse after the stop edge. A timer that never leaves the armed state gives a second pulse on a later edge, or changes the held count without being re-armed. An off-by-one in the counter or in the coincident-edge rule changes the latched value itself. Sweeping every gate-to-clock distance and every calibration period up to the saturation point shows such an error as a count that differs from the exact cycle difference, on the first completion pulse after it occurs.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
    typedef enum logic [1:0] {
        TDT_IDLE  = 2'd0,
        TDT_ARMED = 2'd1,
        TDT_COUNT = 2'd2
    } tdt_state_e;
endpackage

// File: rtl/tdt_sync.sv
// Multi-bit two-process synchronizer with a rising-edge detector per bit.
module tdt_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] sh;
        logic [N-1:0]             prev;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.sh[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            r_d.sh[s] = r_q.sh[s-1];
        end
        r_d.prev = r_q.sh[STAGES-1];
    end

    for (genvar b = 0; b < N; b++) begin : g_edge
        assign rise_o[b] = r_q.sh[STAGES-1][b] & ~r_q.prev[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/tdt_src_mux.sv
// Picks the start event and the coincident-edge rule.
module tdt_src_mux (
    input  logic rise_a,
    input  logic rise_b,
    input  logic rise_conv,
    input  logic src_sel,
    input  logic cal_en,
    input  logic cal_max,
    output logic start_o,
    output logic stop_o,
    output logic zero_ok_o
);
    always_comb begin
        if (cal_en)       start_o = rise_conv;
        else if (src_sel) start_o = rise_b;
        else              start_o = rise_a;
        stop_o    = rise_conv;
        // Full-period calibration must skip the rise that started it.
        zero_ok_o = !(cal_en && cal_max);
    end
endmodule

// File: rtl/tdt_meas.sv
// Arm / wait / count sequencer with saturating counter and result latch.
module tdt_meas
    import tdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             start,
    input  logic             stop,
    input  logic             zero_ok,
    output logic [CNT_W-1:0] result_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        tdt_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] result;
        logic             done;
    } meas_t;

    meas_t m_d, m_q;

    always_comb begin
        m_d      = m_q;
        m_d.done = 1'b0;
        if (arm) begin
            m_d.state  = TDT_ARMED;
            m_d.cnt    = '0;
            m_d.result = '0;
        end else begin
            unique case (m_q.state)
                TDT_ARMED: begin
                    if (start) begin
                        if (stop && zero_ok) begin
                            m_d.result = '0;
                            m_d.done   = 1'b1;
                            m_d.state  = TDT_IDLE;
                        end else begin
                            m_d.cnt   = CNT_ONE;
                            m_d.state = TDT_COUNT;
                        end
                    end
                end
                TDT_COUNT: begin
                    if (stop) begin
                        m_d.result = m_q.cnt;
                        m_d.done   = 1'b1;
                        m_d.state  = TDT_IDLE;
                    end else if (m_q.cnt != CNT_MAX) begin
                        m_d.cnt = m_q.cnt + CNT_ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.state  <= TDT_IDLE;
            m_q.cnt    <= '0;
            m_q.result <= '0;
            m_q.done   <= 1'b0;
        end else begin
            m_q <= m_d;
        end
    end

    assign result_o = m_q.result;
    assign done_o   = m_q.done;

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> (done_o || $past(arm)));

    assert_idle_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.state == TDT_IDLE && !arm && (start || stop)) |=> !done_o);

    assert_arm_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (result_o == '0 && !done_o));

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.state == TDT_COUNT && m_q.cnt == CNT_MAX && !stop && !arm)
        |=> m_q.cnt == CNT_MAX);

    assert_coincident_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.state == TDT_ARMED && !arm && start && stop && zero_ok)
        |=> (done_o && result_o == '0));
endmodule

// File: rtl/trig_delay_timer.sv
module trig_delay_timer #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             src_sel,
    input  logic             cal_en,
    input  logic             cal_max,
    input  logic             gate_a,
    input  logic             gate_b,
    input  logic             conv_clk,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o
);
    localparam int N_IN = 3;

    logic [N_IN-1:0] rise;
    logic            start, stop, zero_ok;

    tdt_sync #(.N(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({conv_clk, gate_b, gate_a}),
        .rise_o  (rise)
    );

    tdt_src_mux u_mux (
        .rise_a    (rise[0]),
        .rise_b    (rise[1]),
        .rise_conv (rise[2]),
        .src_sel   (src_sel),
        .cal_en    (cal_en),
        .cal_max   (cal_max),
        .start_o   (start),
        .stop_o    (stop),
        .zero_ok_o (zero_ok)
    );

    tdt_meas #(.CNT_W(CNT_W)) u_meas (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .start    (start),
        .stop     (stop),
        .zero_ok  (zero_ok),
        .result_o (count_o),
        .done_o   (done_o)
    );

    assert_cal_ignores_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cal_en |-> (start == rise[2]));
endmodule

// File: tb/trig_delay_timer_test.sv
module trig_delay_timer_test;
    localparam int W   = 8;
    localparam int MAX = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0, src_sel = 1'b0, cal_en = 1'b0, cal_max = 1'b0;
    logic gate_a = 1'b0, gate_b = 1'b0, conv_clk = 1'b0;
    logic [W-1:0] count_o;
    logic done_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    trig_delay_timer #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .src_sel(src_sel),
        .cal_en(cal_en), .cal_max(cal_max), .gate_a(gate_a),
        .gate_b(gate_b), .conv_clk(conv_clk), .count_o(count_o),
        .done_o(done_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_arm();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
    endtask

    task automatic watch(input int n, inout int pulses, inout int val);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (done_o) begin
                pulses++;
                val = int'(count_o);
            end
        end
    endtask

    task automatic idle_inputs();
        @(negedge clk);
        gate_a = 1'b0; gate_b = 1'b0; conv_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Gate mode: unselected gate first, selected gate, then conv after d cycles.
    task automatic gate_meas(input logic sel, input int d, input string req);
        int pulses = 0;
        int val = -1;
        int exp;
        src_sel = sel; cal_en = 1'b0;
        do_arm();
        chk("R9 arm clears", int'(count_o), 0);
        repeat (3) @(negedge clk);
        if (sel) gate_a = 1'b1; else gate_b = 1'b1;
        repeat (2) @(negedge clk);
        if (sel) gate_b = 1'b1; else gate_a = 1'b1;
        for (int i = 0; i < d; i++) begin
            @(negedge clk);
            if (done_o) pulses++;
        end
        conv_clk = 1'b1;
        watch(8, pulses, val);
        exp = (d > MAX) ? MAX : d;
        chk(req, val, exp);
        chk("R8 single pulse", pulses, 1);
        repeat (3) @(negedge clk);
        chk("R8 hold", int'(count_o), exp);
        idle_inputs();
    endtask

    // Calibration: conv toggles with period p; gate_a also toggles.
    task automatic cal_meas(input logic mx, input int p, input string req);
        int pulses = 0;
        int val = -1;
        int h = p / 2;
        cal_en = 1'b1; cal_max = mx;
        do_arm();
        repeat (3) @(negedge clk);
        for (int c = 0; c < 3 * p + 10; c++) begin
            @(negedge clk);
            if (done_o) begin
                pulses++;
                val = int'(count_o);
            end
            conv_clk = ((c % p) < h) ? 1'b1 : 1'b0;
            gate_a   = (c % 3 == 1) ? 1'b1 : 1'b0;
        end
        chk(req, val, mx ? ((p > MAX) ? MAX : p) : 0);
        chk("R8 single pulse cal", pulses, 1);
        idle_inputs();
        cal_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int pulses;
        int val;
        repeat (3) @(negedge clk);
        chk("R1 reset count", int'(count_o), 0);
        chk("R1 reset done", int'(done_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 / R3 / R4 sweep of gate-to-clock distance (d=0 is the R4 case)
        for (int d = 0; d <= 40; d++) begin
            gate_meas(1'b0, d, (d == 0) ? "R4 coincident A" : "R2 gate A");
            gate_meas(1'b1, d, (d == 0) ? "R4 coincident B" : "R3 gate B");
        end

        // R7 saturation
        gate_meas(1'b0, MAX - 1, "R7 below max");
        gate_meas(1'b0, MAX, "R7 at max");
        gate_meas(1'b0, MAX + 45, "R7 saturate");

        // R5 full-period calibration sweep and saturation
        for (int p = 2; p <= 30; p++) cal_meas(1'b1, p, "R5 cal max");
        cal_meas(1'b1, MAX + 20, "R7 cal saturate");

        // R6 zero calibration
        for (int p = 2; p <= 8; p++) cal_meas(1'b0, p, "R6 cal min");

        // R9 edges without arming are ignored, then arm clears
        gate_meas(1'b0, 17, "R2 before ignore");
        pulses = 0; val = -1;
        gate_a = 1'b1;
        repeat (5) @(negedge clk);
        conv_clk = 1'b1;
        watch(8, pulses, val);
        chk("R9 unarmed pulses", pulses, 0);
        chk("R9 unarmed count", int'(count_o), 17);
        idle_inputs();
        do_arm();
        chk("R9 arm clears held", int'(count_o), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule